// File: doc/BRIEF.md
# Operand Bypass Select Logic

This block is the forwarding control for a five-stage in-order pipeline. Three operand consumers can take a value that has been computed but not yet written back: the two ALU inputs in the execute stage and the store-data input in the memory stage. For each of them the block compares the consumer's source register number with the destination of each older instruction still in flight. It emits a 2-bit mux select and also drives the chosen operand value. The candidate values come from the execute/memory latch result, the memory/writeback latch result and the value read from the register file.

An older instruction counts as a producer only when its register write enable is set and its destination is not register 0. The ALU inputs prefer the younger producer, the one in the execute/memory latch, over the one in the memory/writeback latch. Store data can only be fed from the memory/writeback latch, and the memory address never takes a bypassed value. All logic is combinational, so the selects and operands are valid in the same cycle as the source numbers. An instruction three stages behind a writer needs no path, because the register file writes in the first half of the cycle and reads in the second.

Top module: `bypass_ctrl`

## Requirements
- R1: The ALU A select is 0, and ALU A equals `xm_result`, when `dx_rs1` matches a valid execute/memory destination.
- R2: The ALU A select is 1, and ALU A equals `mw_result`, when `dx_rs1` matches a valid memory/writeback destination and the execute/memory stage does not match.
- R3: In every other case the ALU A select is 2 and ALU A equals `rf_a`.
- R4: The ALU B select and value follow the rules of R1 to R3, independently, using `dx_rs2` and `rf_b`.
- R5: The store-data select is 1, and `st_data` equals `mw_result`, when `xm_st_src` matches a valid memory/writeback destination. Otherwise it is 2 and `st_data` equals `xm_st_val`. It is never 0.
- R6: A producer whose write enable is 0 never causes a match.
- R7: Register 0 is never forwarded: a source of 0 always yields select 2.
- R8: Selects and operand values are combinational and valid in the same cycle as their inputs.
- R9: Select code 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dx_rs1 | input | REG_AW | First source register of the instruction in decode/execute |
| dx_rs2 | input | REG_AW | Second source register of the instruction in decode/execute |
| xm_st_src | input | REG_AW | Store-data source register of the instruction in execute/memory |
| xm_rd | input | REG_AW | Destination of the instruction in execute/memory |
| xm_wen | input | 1 | Register write enable of the instruction in execute/memory |
| mw_rd | input | REG_AW | Destination of the instruction in memory/writeback |
| mw_wen | input | 1 | Register write enable of the instruction in memory/writeback |
| xm_result | input | XLEN | ALU result held in execute/memory |
| mw_result | input | XLEN | Writeback value held in memory/writeback |
| rf_a | input | XLEN | Register file value for the first source |
| rf_b | input | XLEN | Register file value for the second source |
| xm_st_val | input | XLEN | Store data latched in execute/memory |
| alu_a_sel | output | 2 | ALU A select: 0 execute/memory, 1 memory/writeback, 2 register file |
| alu_b_sel | output | 2 | ALU B select, same encoding |
| st_sel | output | 2 | Store-data select: 1 memory/writeback, 2 latched value |
| alu_a | output | XLEN | Chosen ALU A operand |
| alu_b | output | XLEN | Chosen ALU B operand |
| st_data | output | XLEN | Chosen store data |

## Verification
Every select and every operand is due in the same cycle as the register numbers and candidate values that produce it, with no register anywhere on the path. The driver applies each stimulus at a rising clock edge and queues the expected result. The monitor takes that result from the queue and compares it at the next falling edge, half a period later, once the logic has settled and before the next stimulus is applied. Directed cases cover each priority, write-enable and register-0 corner. A constrained random run follows, drawing register numbers from a small range so that matches and double matches occur often.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    // Encoding of the operand select.
    typedef enum logic [1:0] {
        SRC_XM  = 2'd0,
        SRC_MW  = 2'd1,
        SRC_RF  = 2'd2,
        SRC_RSV = 2'd3
    } fwd_src_e;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] rd,
    input  logic              wen,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wen && (rd != ZERO_REG) && (rd == src);
    end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import bypass_pkg::*;
#(
    parameter bit USE_NEAR = 1'b1
) (
    input  logic     hit_near,
    input  logic     hit_far,
    output fwd_src_e sel
);
    generate
        if (USE_NEAR) begin : g_two_level
            always_comb begin
                if (hit_near)     sel = SRC_XM;
                else if (hit_far) sel = SRC_MW;
                else              sel = SRC_RF;
            end
        end else begin : g_far_only
            logic unused_near;
            assign unused_near = hit_near;
            always_comb begin
                sel = hit_far ? SRC_MW : SRC_RF;
            end
        end
    endgenerate
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import bypass_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fwd_src_e          sel,
    input  logic [XLEN-1:0]   xm_val,
    input  logic [XLEN-1:0]   mw_val,
    input  logic [XLEN-1:0]   rf_val,
    output logic [XLEN-1:0]   out
);
    always_comb begin
        unique case (sel)
            SRC_XM:  out = xm_val;
            SRC_MW:  out = mw_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
    import bypass_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int XLEN   = 32
) (
    input  logic [REG_AW-1:0] dx_rs1,
    input  logic [REG_AW-1:0] dx_rs2,
    input  logic [REG_AW-1:0] xm_st_src,
    input  logic [REG_AW-1:0] xm_rd,
    input  logic              xm_wen,
    input  logic [REG_AW-1:0] mw_rd,
    input  logic              mw_wen,
    input  logic [XLEN-1:0]   xm_result,
    input  logic [XLEN-1:0]   mw_result,
    input  logic [XLEN-1:0]   rf_a,
    input  logic [XLEN-1:0]   rf_b,
    input  logic [XLEN-1:0]   xm_st_val,
    output logic [1:0]        alu_a_sel,
    output logic [1:0]        alu_b_sel,
    output logic [1:0]        st_sel,
    output logic [XLEN-1:0]   alu_a,
    output logic [XLEN-1:0]   alu_b,
    output logic [XLEN-1:0]   st_data
);
    localparam int N_ALU = 2;

    logic [REG_AW-1:0] alu_src  [N_ALU];
    logic [XLEN-1:0]   alu_rf   [N_ALU];
    fwd_src_e          alu_sel_d[N_ALU];
    logic [XLEN-1:0]   alu_val_d[N_ALU];

    assign alu_src[0] = dx_rs1;
    assign alu_src[1] = dx_rs2;
    assign alu_rf[0]  = rf_a;
    assign alu_rf[1]  = rf_b;

    // One forwarding lane per ALU input: near (X/M) beats far (M/W).
    generate
        for (genvar k = 0; k < N_ALU; k++) begin : g_alu
            logic hit_xm;
            logic hit_mw;

            fwd_match #(.REG_AW(REG_AW)) u_m_xm (
                .src(alu_src[k]), .rd(xm_rd), .wen(xm_wen), .hit(hit_xm)
            );
            fwd_match #(.REG_AW(REG_AW)) u_m_mw (
                .src(alu_src[k]), .rd(mw_rd), .wen(mw_wen), .hit(hit_mw)
            );
            fwd_prio #(.USE_NEAR(1'b1)) u_prio (
                .hit_near(hit_xm), .hit_far(hit_mw), .sel(alu_sel_d[k])
            );
            fwd_mux #(.XLEN(XLEN)) u_mux (
                .sel(alu_sel_d[k]), .xm_val(xm_result), .mw_val(mw_result),
                .rf_val(alu_rf[k]), .out(alu_val_d[k])
            );
        end
    endgenerate

    // Store-data lane: only the M/W producer may feed it.
    logic     st_hit_mw;
    fwd_src_e st_sel_d;

    fwd_match #(.REG_AW(REG_AW)) u_st_match (
        .src(xm_st_src), .rd(mw_rd), .wen(mw_wen), .hit(st_hit_mw)
    );
    fwd_prio #(.USE_NEAR(1'b0)) u_st_prio (
        .hit_near(1'b0), .hit_far(st_hit_mw), .sel(st_sel_d)
    );
    fwd_mux #(.XLEN(XLEN)) u_st_mux (
        .sel(st_sel_d), .xm_val(xm_st_val), .mw_val(mw_result),
        .rf_val(xm_st_val), .out(st_data)
    );

    assign alu_a_sel = alu_sel_d[0];
    assign alu_b_sel = alu_sel_d[1];
    assign st_sel    = st_sel_d;
    assign alu_a     = alu_val_d[0];
    assign alu_b     = alu_val_d[1];
endmodule

// File: rtl/bypass_ctrl_chk.sv
module bypass_ctrl_chk #(
    parameter int REG_AW = 5,
    parameter int XLEN   = 32
) (
    input logic [REG_AW-1:0] dx_rs1,
    input logic [REG_AW-1:0] dx_rs2,
    input logic [REG_AW-1:0] xm_st_src,
    input logic [REG_AW-1:0] xm_rd,
    input logic              xm_wen,
    input logic [REG_AW-1:0] mw_rd,
    input logic              mw_wen,
    input logic [XLEN-1:0]   xm_result,
    input logic [XLEN-1:0]   mw_result,
    input logic [XLEN-1:0]   rf_a,
    input logic [XLEN-1:0]   rf_b,
    input logic [XLEN-1:0]   xm_st_val,
    input logic [1:0]        alu_a_sel,
    input logic [1:0]        alu_b_sel,
    input logic [1:0]        st_sel,
    input logic [XLEN-1:0]   alu_a,
    input logic [XLEN-1:0]   alu_b,
    input logic [XLEN-1:0]   st_data
);
    always_comb begin
        // R1: a live X/M producer of rs1 wins
        if (xm_wen && xm_rd != '0 && xm_rd == dx_rs1)
            p_xm_first_r1: assert (alu_a_sel == 2'd0) else $error("r1 select");
        // R2: an M/W pick implies a live M/W producer of rs1
        if (alu_a_sel == 2'd1)
            p_mw_valid_r2: assert (mw_wen && mw_rd == dx_rs1 && mw_rd != '0) else $error("r2 select");
        // R7: register 0 is never forwarded
        if (dx_rs2 == '0)
            p_zero_reg_r7: assert (alu_b_sel == 2'd2) else $error("r7 select");
        // R6: no enabled producer means register file
        if (!xm_wen && !mw_wen)
            p_no_wen_r6: assert (alu_a_sel == 2'd2 && alu_b_sel == 2'd2) else $error("r6 select");
        // R5: store data never takes the X/M code
        p_st_no_xm_r5: assert (st_sel != 2'd0) else $error("r5 select");
        // R9: code 3 never leaves the block
        p_no_rsv_r9: assert (alu_a_sel != 2'd3 && alu_b_sel != 2'd3) else $error("r9 select");
        // R8: data follows the select
        if (alu_b_sel == 2'd0)
            p_data_b_r8: assert (alu_b == xm_result) else $error("r8 data");
        if (st_sel == 2'd2)
            p_data_st_r8: assert (st_data == xm_st_val) else $error("r8 store");
    end

    logic unused_ok;
    assign unused_ok = ^{mw_result, rf_a, rf_b, alu_a, xm_st_src};
endmodule

bind bypass_ctrl bypass_ctrl_chk #(.REG_AW(REG_AW), .XLEN(XLEN)) chk_i (.*);

// File: tb/bypass_ctrl_tb_top.sv
module bypass_ctrl_tb_top;
    localparam int AW = 5;
    localparam int XL = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0] dx_rs1, dx_rs2, xm_st_src, xm_rd, mw_rd;
    logic          xm_wen, mw_wen;
    logic [XL-1:0] xm_result, mw_result, rf_a, rf_b, xm_st_val;
    logic [1:0]    alu_a_sel, alu_b_sel, st_sel;
    logic [XL-1:0] alu_a, alu_b, st_data;

    bypass_ctrl #(.REG_AW(AW), .XLEN(XL)) dut_i (.*);

    typedef struct {
        logic [1:0]    a_sel, b_sel, s_sel;
        logic [XL-1:0] a, b, s;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    function automatic logic [1:0] ref_alu(logic [AW-1:0] src);
        if (xm_wen && xm_rd != 0 && xm_rd == src) return 2'd0;
        if (mw_wen && mw_rd != 0 && mw_rd == src) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [XL-1:0] ref_val(logic [1:0] s, logic [XL-1:0] own);
        return (s == 2'd0) ? xm_result : (s == 2'd1) ? mw_result : own;
    endfunction

    task automatic drive(input logic [AW-1:0] r1, r2, ss, xd, input logic xw,
                         input logic [AW-1:0] md, input logic mwv, input string tag);
        exp_t e;
        @(posedge clk);
        dx_rs1 = r1; dx_rs2 = r2; xm_st_src = ss;
        xm_rd = xd; xm_wen = xw; mw_rd = md; mw_wen = mwv;
        xm_result = $urandom; mw_result = $urandom;
        rf_a = $urandom; rf_b = $urandom; xm_st_val = $urandom;
        e.a_sel = ref_alu(r1);
        e.b_sel = ref_alu(r2);
        e.s_sel = (mwv && md != 0 && md == ss) ? 2'd1 : 2'd2;
        e.a = ref_val(e.a_sel, rf_a);
        e.b = ref_val(e.b_sel, rf_b);
        e.s = (e.s_sel == 2'd1) ? mw_result : xm_st_val;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic cmp(input string what, input string tag, input logic [XL-1:0] act, exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: results are due in the same cycle, compared half a period later.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp("a_sel", e.tag, {30'd0, alu_a_sel}, {30'd0, e.a_sel});
            cmp("b_sel", e.tag, {30'd0, alu_b_sel}, {30'd0, e.b_sel});
            cmp("st_sel", e.tag, {30'd0, st_sel}, {30'd0, e.s_sel});
            cmp("alu_a", e.tag, alu_a, e.a);
            cmp("alu_b", e.tag, alu_b, e.b);
            cmp("st_data", e.tag, st_data, e.s);
        end
    end

    initial begin
        dx_rs1 = 0; dx_rs2 = 0; xm_st_src = 0; xm_rd = 0; mw_rd = 0;
        xm_wen = 0; mw_wen = 0; xm_result = 0; mw_result = 0;
        rf_a = 0; rf_b = 0; xm_st_val = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(5'd3, 5'd4, 5'd6, 5'd0, 1'b0, 5'd0, 1'b0, "R3_idle");
        drive(5'd3, 5'd9, 5'd6, 5'd3, 1'b1, 5'd7, 1'b1, "R1");
        drive(5'd7, 5'd9, 5'd6, 5'd3, 1'b1, 5'd7, 1'b1, "R2");
        drive(5'd8, 5'd8, 5'd8, 5'd8, 1'b1, 5'd8, 1'b1, "R1_prio");
        drive(5'd1, 5'd2, 5'd6, 5'd5, 1'b1, 5'd6, 1'b1, "R3");
        drive(5'd1, 5'd2, 5'd6, 5'd2, 1'b1, 5'd1, 1'b1, "R4");
        drive(5'd2, 5'd2, 5'd2, 5'd2, 1'b0, 5'd2, 1'b0, "R6");
        drive(5'd2, 5'd2, 5'd2, 5'd2, 1'b0, 5'd2, 1'b1, "R6_xm_off");
        drive(5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R7");
        drive(5'd11, 5'd12, 5'd13, 5'd13, 1'b1, 5'd13, 1'b1, "R5");
        drive(5'd11, 5'd12, 5'd13, 5'd13, 1'b1, 5'd14, 1'b1, "R5_nomatch");
        for (int i = 0; i < 400; i++) begin
            drive(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  1'($urandom), AW'($urandom_range(0, 3)), 1'($urandom), "R8_R9_rand");
        end
        @(posedge clk);
        @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 50000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule